// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block carries out the memory half of load and store instructions in a multi-cycle processor. The control unit presents one request at a time. Each request has a 3-bit access mode, a 16-bit operand field, a base address taken from a register, a 32-bit source value for stores, and a destination register tag for loads. The unit then does one of three things. For an immediate load it writes back the sign-extended operand and makes no memory access. For any other load it forms an effective address, reads memory through a registered address/data pair, and writes back the returned word. For a store it forms an effective address, fills the address and data registers, and issues a single write strobe.

The sequencing is a five-state machine. IDLE accepts a request. SETUP loads the address and data registers from the effective-address adder and the source value. READ holds the read strobe until memory acknowledges, and captures the returned word on the acknowledge cycle. WBACK presents the write-back and pulses done. WRITE issues the write strobe and pulses done. The transitions are:
- IDLE→WBACK for an immediate load.
- IDLE→SETUP for any other accepted mode.
- SETUP→READ for a load, and SETUP→WRITE for a store.
- READ→READ while there is no acknowledge, and READ→WBACK on acknowledge.
- WBACK→IDLE and WRITE→IDLE.

Top module: `ldst_agu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, mem_rd, mem_wr and wb_en are low and mem_addr, mem_wdata and wb_data are zero.
- R2: A request is taken on a clock edge where req_valid is high and busy is low. busy is high from the next cycle through the cycle in which done pulses, and is low in the cycle after. A request presented while busy is high is ignored and leaves no trace in any later result.
- R3: Mode encoding is as follows. Bit 2 selects store (1) or load (0). Bits 1:0 select the addressing: 0 immediate, 1 absolute, 2 register-indirect, 3 base-plus-displacement. Mode 3'b100 is not a valid mode. Such a request is ignored: busy stays low and no strobe or write-back follows.
- R4: An immediate load (mode 0) raises wb_en and done in the cycle right after acceptance. wb_data is the operand sign-extended to 32 bits, wb_dst is the request's tag, and mem_rd and mem_wr stay low.
- R5: Absolute modes (1 and 5) use the operand unchanged as the 16-bit word address.
- R6: Register-indirect modes (2 and 6) use req_base as the address.
- R7: Displacement modes (3 and 7) use req_base plus the sign-extended operand, kept to 16 bits, so the sum wraps modulo 65536.
- R8: A non-immediate load holds mem_rd with a stable mem_addr until mem_ack. mem_rdata is captured in the acknowledge cycle. The next cycle carries wb_en and done, with that word on wb_data and the request's tag on wb_dst.
- R9: A store raises mem_wr for exactly one cycle, with mem_addr holding the effective address and mem_wdata holding req_src. done pulses in that same cycle, and wb_en stays low.
- R10: mem_rd, mem_wr and wb_en are never high together. Each completed request produces exactly one write-back or one write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Access mode (store bit, addressing) |
| req_operand | input | 16 | Operand field: immediate, address or displacement |
| req_base | input | 16 | Address part of the base/index register |
| req_src | input | 32 | Store data |
| req_dst | input | 4 | Destination register tag for loads |
| busy | output | 1 | Request in flight |
| done | output | 1 | Completion pulse |
| mem_addr | output | 16 | Address register |
| mem_wdata | output | 32 | Data register (store data) |
| mem_rd | output | 1 | Read strobe, held until acknowledge |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_ack | input | 1 | Read acknowledge, mem_rdata valid |
| mem_rdata | input | 32 | Read data |
| wb_en | output | 1 | Destination write-back enable |
| wb_dst | output | 4 | Destination register tag |
| wb_data | output | 32 | Write-back value |

## Verification
The hardest situation to reach from the ports is a second request arriving while a load is stalled in READ. If that request leaked into the latched fields, it would only show up later as a wrong address or tag. The stimulus sets the memory model to a long acknowledge delay and holds a conflicting request on the inputs for several of the stall cycles. The scoreboard then requires the write-back to match the first request, and requires nothing further to appear. The displacement wrap in both directions, and the invalid store-immediate code, are driven explicitly.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
    typedef enum logic [1:0] {
        AM_IMM  = 2'd0,
        AM_ABS  = 2'd1,
        AM_IND  = 2'd2,
        AM_DISP = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WBACK,
        ST_WRITE
    } state_e;

    localparam int MODE_W = 3;
endpackage

// File: rtl/ldst_agu_ea.sv
module ldst_agu_ea
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OPND_W = 16
) (
    input  amode_e            am,
    input  logic [OPND_W-1:0] opnd,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] disp_ext;

    // sign-extend (or trim) the displacement to address width
    assign disp_ext = ADDR_W'($signed(opnd));

    always_comb begin
        unique case (am)
            AM_ABS:  ea = ADDR_W'(opnd);
            AM_IND:  ea = base;
            AM_DISP: ea = base + disp_ext;
            default: ea = '0;
        endcase
    end
endmodule

// File: rtl/ldst_agu_datapath.sv
module ldst_agu_datapath
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OPND_W = 16,
    parameter int DST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              setup,
    input  logic              capture,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [OPND_W-1:0] req_operand,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_src,
    input  logic [DST_W-1:0]  req_dst,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] ea,
    output amode_e            lat_am,
    output logic              lat_store,
    output logic [OPND_W-1:0] lat_opnd,
    output logic [ADDR_W-1:0] lat_base,
    output logic [DST_W-1:0]  lat_dst,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] lat_src;

    // request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_am    <= AM_IMM;
            lat_store <= 1'b0;
            lat_opnd  <= '0;
            lat_base  <= '0;
            lat_src   <= '0;
            lat_dst   <= '0;
        end else if (accept) begin
            lat_am    <= amode_e'(req_mode[1:0]);
            lat_store <= req_mode[2];
            lat_opnd  <= req_operand;
            lat_base  <= req_base;
            lat_src   <= req_src;
            lat_dst   <= req_dst;
        end
    end

    // address and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mdr <= '0;
        end else if (setup) begin
            mar <= ea;
            mdr <= lat_src;
        end
    end

    // write-back value: immediate at acceptance, memory word on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (accept) begin
            result <= DATA_W'($signed(req_operand));
        end else if (capture) begin
            result <= mem_rdata;
        end
    end
endmodule

// File: rtl/ldst_agu_fsm.sv
module ldst_agu_fsm
    import ldst_agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              lat_store,
    input  logic              mem_ack,
    output logic              accept,
    output logic              setup,
    output logic              capture,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              wb_en
);
    state_e state_q, state_d;
    logic   mode_ok;

    // store with immediate addressing does not exist
    assign mode_ok = !(req_mode[2] && (req_mode[1:0] == AM_IMM));
    assign accept  = (state_q == ST_IDLE) && req_valid && mode_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept)
                    state_d = (req_mode[1:0] == AM_IMM) ? ST_WBACK : ST_SETUP;
            ST_SETUP: state_d = lat_store ? ST_WRITE : ST_READ;
            ST_READ:  if (mem_ack) state_d = ST_WBACK;
            ST_WBACK: state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        setup   = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        wb_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: setup = 1'b1;
            ST_READ: begin
                mem_rd  = 1'b1;
                capture = mem_ack;
            end
            ST_WBACK: begin
                wb_en = 1'b1;
                done  = 1'b1;
            end
            ST_WRITE: begin
                mem_wr = 1'b1;
                done   = 1'b1;
            end
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OPND_W = 16,
    parameter int DST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [OPND_W-1:0] req_operand,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [DATA_W-1:0] req_src,
    input  logic [DST_W-1:0]  req_dst,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_en,
    output logic [DST_W-1:0]  wb_dst,
    output logic [DATA_W-1:0] wb_data
);
    logic              accept, setup, capture, lat_store;
    amode_e            lat_am;
    logic [OPND_W-1:0] lat_opnd;
    logic [ADDR_W-1:0] lat_base, ea;

    ldst_agu_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .lat_store (lat_store),
        .mem_ack   (mem_ack),
        .accept    (accept),
        .setup     (setup),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .wb_en     (wb_en)
    );

    ldst_agu_ea #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) u_ea (
        .am   (lat_am),
        .opnd (lat_opnd),
        .base (lat_base),
        .ea   (ea)
    );

    ldst_agu_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPND_W(OPND_W), .DST_W(DST_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .setup       (setup),
        .capture     (capture),
        .req_mode    (req_mode),
        .req_operand (req_operand),
        .req_base    (req_base),
        .req_src     (req_src),
        .req_dst     (req_dst),
        .mem_rdata   (mem_rdata),
        .ea          (ea),
        .lat_am      (lat_am),
        .lat_store   (lat_store),
        .lat_opnd    (lat_opnd),
        .lat_base    (lat_base),
        .lat_dst     (wb_dst),
        .mar         (mem_addr),
        .mdr         (mem_wdata),
        .result      (wb_data)
    );
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_mode,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ack,
    input logic              wb_en
);
    assert_strobes_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, wb_en}));

    assert_done_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_from_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_bad_mode_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode == 3'b100) |=> !busy);

    assert_wb_is_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    assert_read_to_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ack) |=> (wb_en && done));

    assert_store_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (done && !wb_en));

    assert_store_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
endmodule

bind ldst_agu ldst_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ack   (mem_ack),
    .wb_en     (wb_en)
);

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [15:0] req_operand = '0;
    logic [15:0] req_base = '0;
    logic [31:0] req_src = '0;
    logic [3:0]  req_dst = '0;
    logic        busy, done, mem_rd, mem_wr, wb_en;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, wb_data;
    logic [3:0]  wb_dst;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int ack_wait = 0;
    int wait_cnt = 0;
    bit finished = 0;

    typedef struct {
        bit          is_wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  dst;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    ldst_agu dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_operand(req_operand), .req_base(req_base), .req_src(req_src),
        .req_dst(req_dst), .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .wb_en(wb_en),
        .wb_dst(wb_dst), .wb_data(wb_data)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model: acknowledge after ack_wait stall cycles
    always @(negedge clk) begin
        if (mem_rd) begin
            if (wait_cnt >= ack_wait) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_word(mem_addr);
            end else begin
                mem_ack = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            wait_cnt  = 0;
        end
    end

    // monitor: every write-back or write strobe must match the queue head
    always @(negedge clk) begin
        if (rst_n && (wb_en || mem_wr)) begin
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected event", {16'h0, mem_addr}, '0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(mem_wr == e.is_wr, e.tag, "kind", 32'(mem_wr), 32'(e.is_wr));
                check(done, e.tag, "done", 32'(done), 32'd1);
                if (e.is_wr) begin
                    check(mem_addr == e.addr, e.tag, "store addr", 32'(mem_addr), 32'(e.addr));
                    check(mem_wdata == e.data, e.tag, "store data", mem_wdata, e.data);
                end else begin
                    check(wb_data == e.data, e.tag, "wb data", wb_data, e.data);
                    check(wb_dst == e.dst, e.tag, "wb dst", 32'(wb_dst), 32'(e.dst));
                end
            end
        end
    end

    function automatic logic [15:0] exp_addr(input logic [2:0] m, input logic [15:0] op,
                                             input logic [15:0] b);
        case (m[1:0])
            2'd1:    return op;
            2'd2:    return b;
            2'd3:    return b + op;
            default: return '0;
        endcase
    endfunction

    task automatic drive(input logic [2:0] m, input logic [15:0] op, input logic [15:0] b,
                         input logic [31:0] s, input logic [3:0] d);
        req_valid = 1'b1; req_mode = m; req_operand = op;
        req_base = b; req_src = s; req_dst = d;
    endtask

    task automatic do_req(input logic [2:0] m, input logic [15:0] op, input logic [15:0] b,
                          input logic [31:0] s, input logic [3:0] d, input string tag);
        item_t e;
        logic [15:0] a;
        a = exp_addr(m, op, b);
        e.is_wr = m[2];
        e.addr  = a;
        e.dst   = d;
        e.tag   = tag;
        if (m[2])            e.data = s;
        else if (m[1:0] == 0) e.data = {{16{op[15]}}, op};
        else                 e.data = mem_word(a);
        while (busy) @(negedge clk);
        exp_q.push_back(e);
        drive(m, op, b, s, d);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R2", "busy after accept", 32'(busy), 32'd1);
        if (m == 3'b000)
            check(wb_en && !mem_rd && !mem_wr, "R4", "immediate next cycle",
                  32'(wb_en), 32'd1);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(!busy, "R2", "idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr && !wb_en, "R1", "control low in reset",
              {27'h0, busy, done, mem_rd, mem_wr, wb_en}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_addr == 0 && mem_wdata == 0 && wb_data == 0, "R1", "registers zero",
              mem_wdata | wb_data | 32'(mem_addr), '0);

        // R4 immediate loads, positive and negative
        do_req(3'b000, 16'h7FFF, 16'h1111, 32'h0, 4'h2, "R4");
        do_req(3'b000, 16'h8001, 16'h0, 32'h0, 4'hB, "R4");
        // R5 absolute
        ack_wait = 0;
        do_req(3'b001, 16'hFFF0, 16'h0, 32'h0, 4'h1, "R5");
        do_req(3'b101, 16'h0100, 16'hAAAA, 32'hCAFE_0001, 4'h0, "R5");
        // R6 indirect
        ack_wait = 2;
        do_req(3'b010, 16'hDEAD, 16'h1234, 32'h0, 4'h7, "R6");
        do_req(3'b110, 16'h0, 16'h7C40, 32'h0000_0048, 4'h0, "R6");
        // R7 displacement with wrap both ways
        do_req(3'b011, 16'h0020, 16'hFFF0, 32'h0, 4'h3, "R7");
        do_req(3'b011, 16'hFFFF, 16'h0100, 32'h0, 4'h4, "R7");
        do_req(3'b111, 16'hFFFE, 16'h0001, 32'h1357_9BDF, 4'h0, "R7");
        do_req(3'b111, 16'h0004, 16'h8000, 32'h2468_ACE0, 4'h0, "R9");

        // R3 invalid store-immediate code is ignored
        drive(3'b100, 16'h0055, 16'h0, 32'hFFFF_FFFF, 4'h5);
        @(negedge clk);
        req_valid = 1'b0;
        check(!busy, "R3", "mode 100 not taken", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        check(!busy && exp_q.size() == 0, "R3", "no activity", 32'(busy), 32'd0);

        // R2/R8 request during a long read stall is ignored
        ack_wait = 6;
        begin
            item_t e;
            e.is_wr = 1'b0; e.addr = 16'h0200; e.data = mem_word(16'h0200);
            e.dst = 4'h6; e.tag = "R8";
            exp_q.push_back(e);
            drive(3'b001, 16'h0200, 16'h0, 32'h0, 4'h6);
            @(negedge clk);
            drive(3'b101, 16'h0333, 16'h0444, 32'hBAD0_BAD0, 4'h9);
            repeat (4) begin
                @(negedge clk);
                check(busy, "R2", "busy during stall", 32'(busy), 32'd1);
            end
            req_valid = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
            check(!busy && !mem_wr, "R2", "ignored request left nothing", 32'(busy), 32'd0);
        end
        // follow-up confirms clean state
        ack_wait = 1;
        do_req(3'b010, 16'h0, 16'h0AB0, 32'h0, 4'hC, "R8");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule